// File: doc/BRIEF.md
# Private System Region Address Decoder

This block decodes accesses into a 1 MiB private system region and picks which register target should answer each one. The targets are a system control block, a pair of timer register sets banked by security state, an optional error-reporting register block, and a built-in default responder. Several windows overlap, and a fixed priority settles which one wins. The timer window sits inside the control block window and takes precedence over it. Every mapped target takes precedence over the default responder.

The secure attribute of a request does two jobs. It picks the timer bank. It also decides how the non-secure alias window behaves. A secure access through the alias is passed on to the real control or timer target with the secure attribute cleared. A non-secure access through the alias is answered by the default responder. Unmapped space reads as zero and drops writes for privileged code, and it faults for unprivileged code.

The decode is purely combinational: the target select, the adjusted secure attribute and any local response come out in the same cycle as the request. Two parameters set whether the security extension and the error-reporting block are present. When a target is absent, its window falls through to the default responder.

Top module: `ppb_decoder`

## Requirements
- R1: An address outside 0xE000_0000..0xE00F_FFFF gives `tgt_sel` = 0 and `rsp_local` = 0, and `tgt_secure` equals `req_secure`.
- R2: An address in 0xE000_E000..0xE000_EFFF that is outside the timer window selects the control block (`tgt_sel` = 5'b00001) and passes `req_secure` through unchanged.
- R3: An address in 0xE000_E010..0xE000_E0EF selects a timer, and this takes precedence over the control block. With the security extension present, a secure access selects the secure timer (5'b00100). A non-secure access selects the non-secure timer (5'b00010). Without the extension, every access goes to the non-secure timer.
- R4: With the error block enabled, an address in 0xE000_5000..0xE000_5FFF selects it (5'b01000).
- R5: Any other address in the region selects the default responder (5'b10000). The responder sets `rsp_local` = 1, drives `tgt_secure` = 0 and `rsp_rdata` = 0, and raises no fault for a privileged access of 1 to 8 bytes, read or write.
- R6: The default responder raises `rsp_fault` for an unprivileged access.
- R7: The default responder raises `rsp_fault` when `req_bytes` is 0 or greater than 8.
- R8: With the security extension present, a secure access in 0xE002_E000..0xE002_EFFF is forwarded with `tgt_secure` = 0. An address in 0xE002_E010..0xE002_E0EF goes to the non-secure timer, and the rest of that range goes to the control block.
- R9: A non-secure access to the alias window is answered by the default responder under the R5 to R7 rules.
- R10: `tgt_sel` has at most one bit set, and `rsp_local` equals `tgt_sel[4]`.
- R11: With the security extension and the error block both disabled, the alias window and the error window fall through to the default responder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_addr | input | 32 | Byte address of the access |
| req_bytes | input | 4 | Access size in bytes |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_secure | input | 1 | Secure attribute of the request |
| req_priv | input | 1 | Privileged attribute of the request |
| tgt_sel | output | 5 | One-hot target: 0 control, 1 timer non-secure, 2 timer secure, 3 error block, 4 default |
| tgt_secure | output | 1 | Secure attribute forwarded to the selected target |
| rsp_local | output | 1 | The decoder answers the access itself |
| rsp_fault | output | 1 | Bus fault for a locally answered access |
| rsp_rdata | output | RD_W | Read data for a locally answered access |

## Verification
The block holds no state, so any decode fault shows up at the ports in the same cycle as the request. The usual form is a wrong select bit, a secure attribute that was not cleared, or a missing fault. The risky points are the window edges: 0xE000_E00F/0xE000_E010 and 0xE000_E0EF/0xE000_E0F0 for the timer override, and the 4 KiB boundaries of the alias and error windows. These edges are driven directly, and each one is tried with every combination of the secure and privileged attributes. A second instance with both options disabled shows the fall-through behaviour.

// File: rtl/ppb_decoder.sv
module ppb_decoder #(
  parameter int HAS_SEC = 1,
  parameter int HAS_ERR = 1,
  parameter int RD_W    = 64
) (
  input  logic [31:0]     req_addr,
  input  logic [3:0]      req_bytes,
  input  logic            req_write,
  input  logic            req_secure,
  input  logic            req_priv,
  output logic [4:0]      tgt_sel,
  output logic            tgt_secure,
  output logic            rsp_local,
  output logic            rsp_fault,
  output logic [RD_W-1:0] rsp_rdata
);

  localparam logic [4:0] SEL_CTL = 5'b00001;
  localparam logic [4:0] SEL_TNS = 5'b00010;
  localparam logic [4:0] SEL_TS  = 5'b00100;
  localparam logic [4:0] SEL_ERR = 5'b01000;
  localparam logic [4:0] SEL_DFL = 5'b10000;

  wire [19:0] off     = req_addr[19:0];
  wire        in_rgn  = req_addr[31:20] == 12'hE00;
  wire        low_tmr = off[11:0] >= 12'h010 && off[11:0] < 12'h0F0;
  wire        ctl_win = off[19:12] == 8'h0E;
  wire        tmr_win = ctl_win && low_tmr;
  wire        als_win = (HAS_SEC != 0) && off[19:12] == 8'h2E;
  wire        als_tmr = als_win && low_tmr;
  wire        err_win = (HAS_ERR != 0) && off[19:12] == 8'h05;
  wire        size_ok = req_bytes >= 4'd1 && req_bytes <= 4'd8;

  assign rsp_rdata = '0;

  always_comb begin
    logic use_dfl;
    use_dfl    = 1'b0;
    tgt_sel    = '0;
    tgt_secure = req_secure;
    rsp_local  = 1'b0;
    rsp_fault  = 1'b0;
    if (in_rgn) begin
      if (als_win) begin
        if (req_secure) begin
          tgt_secure = 1'b0;
          tgt_sel    = als_tmr ? SEL_TNS : SEL_CTL;
        end else begin
          use_dfl = 1'b1;
        end
      end else if (tmr_win) begin
        tgt_sel = ((HAS_SEC != 0) && req_secure) ? SEL_TS : SEL_TNS;
      end else if (ctl_win) begin
        tgt_sel = SEL_CTL;
      end else if (err_win) begin
        tgt_sel = SEL_ERR;
      end else begin
        use_dfl = 1'b1;
      end
      if (use_dfl) begin
        tgt_sel    = SEL_DFL;
        tgt_secure = 1'b0;
        rsp_local  = 1'b1;
        rsp_fault  = !req_priv || !size_ok;
      end
    end

    // R10
    sel_onehot_chk: assert ($onehot0(tgt_sel));
    // R10
    local_match_chk: assert (rsp_local == tgt_sel[4]);
    // R6
    if (rsp_local && !req_priv) user_fault_chk: assert (rsp_fault);
    // R5
    if (rsp_local && req_write && req_priv && size_ok) wr_ignore_chk: assert (!rsp_fault);
    // R8
    if (als_win && req_secure && in_rgn) alias_clear_chk: assert (!tgt_secure && !rsp_local);
    // R3
    if (tgt_sel[2]) tmr_bank_chk: assert (HAS_SEC != 0 && req_secure);
    // R1
    if (!in_rgn) outside_chk: assert (tgt_sel == 5'b0 && !rsp_fault);
  end

endmodule

// File: tb/ppb_decoder_bench.sv
module ppb_decoder_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] a;
  logic [3:0]  nb;
  logic        wr, sec, prv;
  logic [4:0]  sel_f, sel_b;
  logic        so_f, so_b, lo_f, lo_b, fa_f, fa_b;
  logic [63:0] rd_f, rd_b;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  ppb_decoder u_ppb_decoder (.req_addr(a), .req_bytes(nb), .req_write(wr), .req_secure(sec),
    .req_priv(prv), .tgt_sel(sel_f), .tgt_secure(so_f), .rsp_local(lo_f), .rsp_fault(fa_f),
    .rsp_rdata(rd_f));
  ppb_decoder #(.HAS_SEC(0), .HAS_ERR(0)) u_ppb_decoder_bare (.req_addr(a), .req_bytes(nb),
    .req_write(wr), .req_secure(sec), .req_priv(prv), .tgt_sel(sel_b), .tgt_secure(so_b),
    .rsp_local(lo_b), .rsp_fault(fa_b), .rsp_rdata(rd_b));

  function automatic string tag_of(input logic [31:0] ad, input bit hs, input bit he, input bit s);
    if (ad < 32'hE000_0000 || ad > 32'hE00F_FFFF) return "R1";
    if (hs && ad >= 32'hE002_E000 && ad <= 32'hE002_EFFF) return s ? "R8" : "R9";
    if (ad >= 32'hE000_E010 && ad < 32'hE000_E0F0) return "R3";
    if (ad >= 32'hE000_E000 && ad <= 32'hE000_EFFF) return "R2";
    if (he && ad >= 32'hE000_5000 && ad <= 32'hE000_5FFF) return "R4";
    if (!hs && !he && ((ad >= 32'hE002_E000 && ad <= 32'hE002_EFFF) ||
        (ad >= 32'hE000_5000 && ad <= 32'hE000_5FFF))) return "R11";
    return "R5/R6/R7";
  endfunction

  task automatic model(input logic [31:0] ad, input int bytes, input bit s, input bit p,
                       input bit hs, input bit he,
                       output logic [4:0] es, output bit eo, output bit el, output bit ef);
    bit dfl = 1'b0;
    es = 5'd0; eo = s; el = 1'b0; ef = 1'b0;
    if (ad < 32'hE000_0000 || ad > 32'hE00F_FFFF) return;
    if (hs && ad >= 32'hE002_E000 && ad <= 32'hE002_EFFF) begin
      if (s) begin
        eo = 1'b0;
        es = (ad >= 32'hE002_E010 && ad < 32'hE002_E0F0) ? 5'd2 : 5'd1;
      end else dfl = 1'b1;
    end else if (ad >= 32'hE000_E010 && ad < 32'hE000_E0F0) es = (hs && s) ? 5'd4 : 5'd2;
    else if (ad >= 32'hE000_E000 && ad <= 32'hE000_EFFF) es = 5'd1;
    else if (he && ad >= 32'hE000_5000 && ad <= 32'hE000_5FFF) es = 5'd8;
    else dfl = 1'b1;
    if (dfl) begin
      es = 5'd16; eo = 1'b0; el = 1'b1;
      ef = !p || bytes < 1 || bytes > 8;
    end
  endtask

  task automatic compare_one(input bit hs, input bit he, input logic [4:0] gs, input logic go,
                             input logic gl, input logic gf, input logic [63:0] gr);
    logic [4:0] es; bit eo, el, ef;
    string t;
    model(a, int'(nb), sec, prv, hs, he, es, eo, el, ef);
    t = tag_of(a, hs, he, sec);
    n_run++;
    if (gs !== es || go !== eo || gl !== el || gf !== ef || gr !== 64'd0) begin
      n_fail++;
      $display("FAIL %s (R10) addr=%h sec=%0d priv=%0d bytes=%0d: sel/sec/local/fault/rd act=%b/%b/%b/%b/%h exp=%b/%b/%b/%b/0",
               t, a, sec, prv, nb, gs, go, gl, gf, gr, es, eo, el, ef);
    end
  endtask

  always @(posedge clk) if (!done) begin
    compare_one(1'b1, 1'b1, sel_f, so_f, lo_f, fa_f, rd_f);
    compare_one(1'b0, 1'b0, sel_b, so_b, lo_b, fa_b, rd_b);
  end

  task automatic drive(input logic [31:0] ad, input logic [3:0] b, input bit w, input bit s, input bit p);
    @(negedge clk);
    a = ad; nb = b; wr = w; sec = s; prv = p;
  endtask

  logic [31:0] edges [0:21] = '{32'hDFFF_FFFF, 32'hE000_0000, 32'hE00F_FFFF, 32'hE010_0000,
    32'hE000_DFFF, 32'hE000_E000, 32'hE000_E00F, 32'hE000_E010, 32'hE000_E0EF, 32'hE000_E0F0,
    32'hE000_EFFF, 32'hE000_F000, 32'hE000_4FFF, 32'hE000_5000, 32'hE000_5FFF, 32'hE000_6000,
    32'hE002_DFFF, 32'hE002_E000, 32'hE002_E00F, 32'hE002_E010, 32'hE002_E0EF, 32'hE002_EFFF};

  initial begin
    a = 32'h0; nb = 4'd4; wr = 1'b0; sec = 1'b0; prv = 1'b1;
    foreach (edges[i])
      for (int k = 0; k < 8; k++)
        drive(edges[i], 4'd4, k[2], k[0], k[1]);
    for (int b = 0; b < 16; b++) begin
      drive(32'hE000_1000, b[3:0], b[0], 1'b0, 1'b1);
      drive(32'hE002_E400, b[3:0], 1'b1, 1'b0, 1'b1);
    end
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] base;
      case (r[2:0])
        3'd0: base = 32'hE000_E000;
        3'd1: base = 32'hE002_E000;
        3'd2: base = 32'hE000_5000;
        3'd3: base = 32'hE000_0000 | {12'h0, r[31:12]};
        3'd4: base = {r[31:12], 12'h000};
        default: base = 32'hE000_E000 | {24'h0, r[15:8]};
      endcase
      drive(base + {24'h0, r[23:16]}, r[27:24], r[28], r[29], r[30]);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule